// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a processor that runs each instruction over several clock cycles and shares one memory and one ALU between all of them. It is a Moore state machine: every control output depends only on the current state. Each instruction starts with a fetch cycle and a decode cycle. The opcode is sampled at the end of decode and picks one of five paths: word load, word store, register-register ALU operation, branch-if-equal, or jump. Each path ends by going back to fetch.

The outputs drive the shared datapath. They select the memory address source, strobe memory reads and writes, load the instruction register, steer the two ALU operand multiplexers, select the ALU operation class, and choose the next-PC source. They also give the PC an unconditional or a conditional (zero-gated) write, and they steer and enable the register-file write. During decode the ALU adds the sign-extended, shifted offset to the already advanced PC. This computes a possible branch target before the instruction class is known. The opcode and all outputs are plain level signals with no handshake. The sequencer advances on every clock.

Top module: `mc_ctrl_seq`

## Requirements
- R1: An active-low asynchronous reset puts the block in the fetch state. The fetch outputs appear while reset is low and stay until the first clock edge after release.
- R2: Fetch drives mem_rd=1, ir_ld=1, pc_ld=1, alu_b_sel=1, with addr_sel=0, alu_a_sel=0, alu_op=0 and pc_src=0. The next state is always decode.
- R3: Decode drives alu_a_sel=0, alu_b_sel=3 and alu_op=0, with every memory, register-file and PC write strobe at 0.
- R4: At the end of decode the opcode selects the path. The codes are 6'b000000 for register-register, 6'b100011 for load, 6'b101011 for store, 6'b000100 for branch-if-equal and 6'b000010 for jump. Any other code returns directly to fetch.
- R5: Load and store first pass through an address state with alu_a_sel=1, alu_b_sel=2 and alu_op=0.
- R6: A load then reads memory with addr_sel=1 and mem_rd=1. It next writes back with rf_wr=1, rf_dst_sel=0 and rf_wb_sel=1, and then returns to fetch.
- R7: A store writes memory with addr_sel=1 and mem_wr=1, then returns to fetch.
- R8: A register-register instruction executes with alu_a_sel=1, alu_b_sel=0 and alu_op=2. It then completes with rf_wr=1, rf_dst_sel=1 and rf_wb_sel=0, and returns to fetch.
- R9: A branch completes in one state with alu_a_sel=1, alu_b_sel=0, alu_op=1, pc_src=1 and pc_ld_cond=1, then returns to fetch.
- R10: A jump completes in one state with pc_ld=1 and pc_src=2, then returns to fetch.
- R11: In every state, each output not named for that state is 0. mem_rd and mem_wr are never both 1, and neither are pc_ld and pc_ld_cond.
- R12: The opcode has no effect in any state other than decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| addr_sel | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_ld | output | 1 | Instruction register load |
| alu_a_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 0 = reg B, 1 = constant 4, 2 = sign-extended immediate, 3 = shifted immediate |
| alu_op | output | 2 | ALU class: 0 = add, 1 = subtract, 2 = function field |
| pc_src | output | 2 | Next PC: 0 = ALU output, 1 = ALU result register, 2 = jump target |
| pc_ld | output | 1 | Unconditional PC write |
| pc_ld_cond | output | 1 | PC write gated by ALU zero |
| rf_dst_sel | output | 1 | Destination register: 0 = rt field, 1 = rd field |
| rf_wb_sel | output | 1 | Write-back data: 0 = ALU result register, 1 = memory data register |
| rf_wr | output | 1 | Register-file write enable |

## Verification
The state register is the only register between the opcode and the outputs. Each output therefore reflects the state entered at the last rising edge, and the opcode acts only at the edge that ends decode. Load takes five cycles from fetch to fetch, store and register-register take four, branch and jump take three, and an unsupported code takes two. The bench compares the whole output word at each falling edge, one comparison per cycle of a path. It changes the opcode only at falling edges, and it holds a scrambled code in every cycle except decode. Reset is checked asynchronously by asserting it mid-path and sampling before any clock edge.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MADDR, ST_MRD, ST_MWR,
    ST_LDWB, ST_REXE, ST_RWB, ST_BRCH, ST_JMP
  } state_e;

  typedef enum logic [2:0] {
    CL_RTYPE, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP, CL_OTHER
  } iclass_e;

  typedef struct packed {
    logic             addr_sel;
    logic             mem_rd;
    logic             mem_wr;
    logic             ir_ld;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic [SEL_W-1:0] alu_op;
    logic [SEL_W-1:0] pc_src;
    logic             pc_ld;
    logic             pc_ld_cond;
    logic             rf_dst_sel;
    logic             rf_wb_sel;
    logic             rf_wr;
  } ctrl_t;
endpackage

// File: rtl/mcs_classify.sv
module mcs_classify
  import mcs_pkg::*;
#(
  parameter int          OP_W      = 6,
  parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
  input  logic [OP_W-1:0] opcode,
  output iclass_e         cls
);
  always_comb begin
    unique case (opcode)
      OP_RTYPE:  cls = CL_RTYPE;
      OP_LOAD:   cls = CL_LOAD;
      OP_STORE:  cls = CL_STORE;
      OP_BRANCH: cls = CL_BRANCH;
      OP_JUMP:   cls = CL_JUMP;
      default:   cls = CL_OTHER;
    endcase
  end
endmodule

// File: rtl/mcs_next.sv
module mcs_next
  import mcs_pkg::*;
(
  input  state_e  cur,
  input  iclass_e cls,
  output state_e  nxt
);
  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        unique case (cls)
          CL_LOAD, CL_STORE: nxt = ST_MADDR;
          CL_RTYPE:          nxt = ST_REXE;
          CL_BRANCH:         nxt = ST_BRCH;
          CL_JUMP:           nxt = ST_JMP;
          default:           nxt = ST_FETCH;
        endcase
      end
      // the memory-address state has to know load from store without the
      // opcode (ignored outside decode), so the class is carried in cls_q
      ST_MADDR:  nxt = (cls == CL_LOAD) ? ST_MRD : ST_MWR;
      ST_MRD:    nxt = ST_LDWB;
      ST_REXE:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcs_outs.sv
module mcs_outs
  import mcs_pkg::*;
(
  input  state_e cur,
  output ctrl_t  ctl
);
  always_comb begin
    ctl = '0;
    unique case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_ld     = 1'b1;
        ctl.alu_b_sel = 2'd1;
        ctl.pc_ld     = 1'b1;
      end
      ST_DECODE: ctl.alu_b_sel = 2'd3;
      ST_MADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = 2'd2;
      end
      ST_MRD: begin
        ctl.addr_sel = 1'b1;
        ctl.mem_rd   = 1'b1;
      end
      ST_MWR: begin
        ctl.addr_sel = 1'b1;
        ctl.mem_wr   = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_wb_sel = 1'b1;
        ctl.rf_wr     = 1'b1;
      end
      ST_REXE: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_op    = 2'd2;
      end
      ST_RWB: begin
        ctl.rf_dst_sel = 1'b1;
        ctl.rf_wr      = 1'b1;
      end
      ST_BRCH: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_op     = 2'd1;
        ctl.pc_src     = 2'd1;
        ctl.pc_ld_cond = 1'b1;
      end
      ST_JMP: begin
        ctl.pc_src = 2'd2;
        ctl.pc_ld  = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
  import mcs_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  opcode,
  output logic             addr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_ld,
  output logic             alu_a_sel,
  output logic [SEL_W-1:0] alu_b_sel,
  output logic [SEL_W-1:0] alu_op,
  output logic [SEL_W-1:0] pc_src,
  output logic             pc_ld,
  output logic             pc_ld_cond,
  output logic             rf_dst_sel,
  output logic             rf_wb_sel,
  output logic             rf_wr
);
  state_e  state_q, state_d;
  iclass_e cls_now, cls_q, cls_sel;
  ctrl_t   ctl;

  mcs_classify #(
    .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
  ) u_cls (
    .opcode(opcode),
    .cls   (cls_now)
  );

  // opcode is used live only in decode; elsewhere the latched class rules
  assign cls_sel = (state_q == ST_DECODE) ? cls_now : cls_q;

  mcs_next u_nxt (
    .cur(state_q),
    .cls(cls_sel),
    .nxt(state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      cls_q   <= CL_OTHER;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DECODE) cls_q <= cls_now;
    end
  end

  mcs_outs u_out (
    .cur(state_q),
    .ctl(ctl)
  );

  assign addr_sel   = ctl.addr_sel;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign ir_ld      = ctl.ir_ld;
  assign alu_a_sel  = ctl.alu_a_sel;
  assign alu_b_sel  = ctl.alu_b_sel;
  assign alu_op     = ctl.alu_op;
  assign pc_src     = ctl.pc_src;
  assign pc_ld      = ctl.pc_ld;
  assign pc_ld_cond = ctl.pc_ld_cond;
  assign rf_dst_sel = ctl.rf_dst_sel;
  assign rf_wb_sel  = ctl.rf_wb_sel;
  assign rf_wr      = ctl.rf_wr;
endmodule

// File: rtl/mcs_chk.sv
module mcs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_ld,
  input logic       alu_a_sel,
  input logic [1:0] alu_b_sel,
  input logic [1:0] alu_op,
  input logic       pc_ld,
  input logic       pc_ld_cond,
  input logic       rf_dst_sel,
  input logic       rf_wb_sel,
  input logic       rf_wr
);
  p_reset_fetch_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (mem_rd && ir_ld && pc_ld && !addr_sel));

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |=> (alu_b_sel == 2'd3 && !alu_a_sel && !pc_ld && !mem_rd));

  p_addr_to_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_b_sel == 2'd2) |=> (addr_sel && (mem_rd ^ mem_wr)));

  p_load_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_sel) |=> (rf_wr && rf_wb_sel && !rf_dst_sel));

  p_store_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_ld);

  p_rexe_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 2'd2) |=> (rf_wr && rf_dst_sel && !rf_wb_sel));

  p_branch_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld_cond |=> ir_ld);

  p_mem_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_pc_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_ld && pc_ld_cond));
endmodule

bind mc_ctrl_seq mcs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .ir_ld(ir_ld), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
  .alu_op(alu_op), .pc_ld(pc_ld), .pc_ld_cond(pc_ld_cond),
  .rf_dst_sel(rf_dst_sel), .rf_wb_sel(rf_wb_sel), .rf_wr(rf_wr)
);

// File: tb/sim_mc_ctrl_seq.sv
`timescale 1ns/1ps
module sim_mc_ctrl_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h3f;
  logic       addr_sel, mem_rd, mem_wr, ir_ld, alu_a_sel, pc_ld, pc_ld_cond;
  logic       rf_dst_sel, rf_wb_sel, rf_wr;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mc_ctrl_seq u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src), .pc_ld(pc_ld),
    .pc_ld_cond(pc_ld_cond), .rf_dst_sel(rf_dst_sel), .rf_wb_sel(rf_wb_sel),
    .rf_wr(rf_wr)
  );

  // word: addr,rd,wr,ir,a,b[2],op[2],src[2],pcld,cond,dst,wb,rw
  localparam logic [15:0] E_FETCH = {1'b0,1'b1,1'b0,1'b1,1'b0,2'd1,2'd0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0};
  localparam logic [15:0] E_DEC   = {1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [15:0] E_ADDR  = {1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [15:0] E_LRD   = {1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [15:0] E_LWB   = {1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b1};
  localparam logic [15:0] E_SWR   = {1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [15:0] E_REX   = {1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,2'd2,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [15:0] E_RWB   = {1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,1'b1,1'b0,1'b1};
  localparam logic [15:0] E_BR    = {1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,2'd1,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0};
  localparam logic [15:0] E_JMP   = {1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0};

  // entry: opcode[6], length[3], five expected words (unused = 0)
  localparam int NV = 8;
  localparam logic [88:0] VEC [NV] = '{
    {6'b100011, 3'd5, E_FETCH, E_DEC, E_ADDR, E_LRD, E_LWB},  // R6 load
    {6'b101011, 3'd4, E_FETCH, E_DEC, E_ADDR, E_SWR, 16'h0},  // R7 store
    {6'b000000, 3'd4, E_FETCH, E_DEC, E_REX,  E_RWB, 16'h0},  // R8 reg-reg
    {6'b000100, 3'd3, E_FETCH, E_DEC, E_BR,   16'h0, 16'h0},  // R9 branch
    {6'b000010, 3'd3, E_FETCH, E_DEC, E_JMP,  16'h0, 16'h0},  // R10 jump
    {6'b111111, 3'd2, E_FETCH, E_DEC, 16'h0,  16'h0, 16'h0},  // R4 unsupported
    {6'b100010, 3'd2, E_FETCH, E_DEC, 16'h0,  16'h0, 16'h0},  // R4 near-load code
    {6'b101011, 3'd4, E_FETCH, E_DEC, E_ADDR, E_SWR, 16'h0}   // R12 store after junk
  };

  function automatic logic [15:0] outw();
    return {addr_sel, mem_rd, mem_wr, ir_ld, alu_a_sel, alu_b_sel, alu_op,
            pc_src, pc_ld, pc_ld_cond, rf_dst_sel, rf_wb_sel, rf_wr};
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (outw() !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, outw(), exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 reset held", E_FETCH);
    @(negedge clk);
    check("R1 reset still held", E_FETCH);
    rst_n = 1'b1;
    // vector walk: every check at a falling edge, one per state
    for (int v = 0; v < NV; v++) begin
      logic [5:0] op;
      int n;
      op = VEC[v][88:83];
      n  = int'(VEC[v][82:80]);
      opcode = ~op;                      // R12: junk while not decoding
      for (int s = 0; s < n; s++) begin
        logic [15:0] e;
        e = VEC[v][79 - 16*s -: 16];
        if (s == 1) opcode = op;
        if (s == 2) opcode = ~op;
        check($sformatf("R2/R3/R4/R11/R12 vec%0d step%0d", v, s), e);
        @(negedge clk);
      end
    end
    // R2: after all paths, back in fetch
    check("R2 fetch after last path", E_FETCH);
    // R12: wrong code held throughout decode except sampled cycle -> jump path
    @(negedge clk);
    opcode = 6'b000010;
    check("R3 decode", E_DEC);
    @(negedge clk);
    opcode = 6'b100011;
    check("R10 jump unaffected by later code", E_JMP);
    @(negedge clk);
    check("R10 jump returns to fetch", E_FETCH);
    // R1: asynchronous reset in the middle of a load
    @(negedge clk);
    opcode = 6'b100011;
    check("R3 decode before reset", E_DEC);
    @(negedge clk);
    check("R5 address state", E_ADDR);
    #1 rst_n = 1'b0;
    #1 check("R1 async reset mid-path", E_FETCH);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 fetch after release", E_FETCH);
    @(negedge clk);
    check("R2 decode follows fetch", E_DEC);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule